// File: doc/BRIEF.md
# Paired Instruction Sample Selector

This block picks two instructions out of the fetch stream for one profiling event, so that software can later estimate how much the two overlapped in flight. When a sample request is accepted, a free-running LFSR supplies a random distance magnitude `k` in the range 1..W and a sign. The block then watches the fetch stream and raises a one-cycle tag on exactly two fetch slots. The earlier of the pair always receives tag A and the later receives tag B, so two replicated capture slots can be wired to fixed roles.

For a positive distance, the first fetch after acceptance is tagged A and the fetch `k` slots later is tagged B. For a negative distance, the nominal first instruction is delayed by W fetches. The instruction `k` fetches ahead of it, which is the earlier one, takes tag A at fetch index W-k, and the nominal instruction takes tag B at fetch index W. The signed distance of the second instruction relative to the nominal first is held on `pair_dist` for the whole event.

Each capture slot reports when its record is final, whether the instruction retired or aborted. The block raises its completion pulse only once both reports are in. A pipeline flush that arrives before tag B is issued marks the pair invalid.

Top module: `paired_sample_sel`

## Requirements
- R1: After reset `busy`, `tag_a`, `tag_b` and `pair_done` are 0, and no tag is raised while `busy` is 0.
- R2: A `sample_req` is accepted only while `busy` is 0. `busy` is 1 from the cycle after acceptance until the cycle in which `pair_done` is 1, where `busy` is 0. Requests made while busy are ignored, and `pair_dist` stays unchanged while busy.
- R3: `pair_dist` is a two's complement value of log2(W)+2 bits, valid from the cycle after acceptance. Its magnitude is in 1..W and is never 0. With the default parameters both signs occur.
- R4: Fetch index n is the (n+1)-th cycle with `fetch_valid`=1 after the acceptance edge. For a positive distance k, `tag_a` is high in the cycle of fetch index 0 and `tag_b` is high in the cycle of fetch index k.
- R5: For a negative distance -k, `tag_a` is high at fetch index W-k and `tag_b` is high at fetch index W. Tag A always comes before tag B.
- R6: Each pair raises `tag_a` at most once and `tag_b` at most once, never both in the same cycle, and only in cycles with `fetch_valid`=1.
- R7: A final report from a slot counts only after that slot was tagged. For a pair with both tags, `pair_done` is a one-cycle pulse in the cycle after the first cycle in which both slots have reported final, with `pair_valid`=1.
- R8: A `flush` while tag B is still outstanding suppresses any tag in that cycle and marks the pair invalid. `pair_done` then pulses with `pair_valid`=0 in the cycle after the first cycle in which slot A has reported final, or in the cycle after the flush if tag A was never given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_req | input | 1 | Start one paired sample event |
| fetch_valid | input | 1 | One instruction fetched this cycle |
| flush | input | 1 | Pipeline flush |
| slot_a_final | input | 1 | Capture slot A record is final (retired or aborted) |
| slot_b_final | input | 1 | Capture slot B record is final (retired or aborted) |
| busy | output | 1 | A pair event is in progress |
| tag_a | output | 1 | Tag the instruction fetched this cycle into slot A |
| tag_b | output | 1 | Tag the instruction fetched this cycle into slot B |
| pair_done | output | 1 | One-cycle completion pulse |
| pair_valid | output | 1 | Pair is usable, meaningful while `pair_done` is 1 |
| pair_dist | output | log2(W)+2 | Signed fetch distance of the pair |

## Verification
The tags are combinational on the fetch cycle itself, so the bench drives each cycle's inputs at the falling edge and compares the tags against its own fetch-index count one time step later, in the same cycle. `pair_dist` and `busy` are due one edge after acceptance and are read at the following falling edge. `pair_done` is due one edge after the cycle in which the completing condition first holds. The bench therefore carries a one-cycle predicted flag forward and compares `pair_done` and `pair_valid` against it in every cycle. This also catches a pulse that comes early, late or twice.

// File: rtl/psel_pkg.sv
package psel_pkg;

   typedef enum logic [1:0] {
      PS_IDLE = 2'd0,
      PS_RUN  = 2'd1,
      PS_WAIT = 2'd2
   } psel_state_e;

   function automatic int unsigned psel_log2(input int unsigned v);
      return $clog2(v);
   endfunction

endpackage

// File: rtl/psel_lfsr.sv
module psel_lfsr #(
   parameter int unsigned      LW   = 16,
   parameter int unsigned      OW   = 5,
   parameter logic [LW-1:0]    TAPS = 16'hB400,
   parameter logic [LW-1:0]    SEED = 16'hACE1
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [OW-1:0] rnd_o
);
   logic [LW-1:0] state_q;

   if (OW > LW) begin : g_bad_ow
      $error("psel_lfsr: OW must not exceed LW");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("psel_lfsr: SEED must be nonzero");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEED;
      end else if (state_q[0]) begin
         state_q <= (state_q >> 1) ^ TAPS;
      end else begin
         state_q <= state_q >> 1;
      end
   end

   assign rnd_o = state_q[OW-1:0];
endmodule

// File: rtl/psel_offset.sv
module psel_offset #(
   parameter int unsigned W         = 16,
   parameter bit          ALLOW_NEG = 1'b1,
   localparam int unsigned LOG2W    = $clog2(W),
   localparam int unsigned CW       = LOG2W + 1
) (
   input  logic [LOG2W:0]  rnd_i,
   output logic [CW-1:0]   mag_o,
   output logic            neg_o
);
   // Low bits give 0..W-1; adding one maps them onto 1..W, so zero never occurs.
   assign mag_o = CW'(rnd_i[LOG2W-1:0]) + CW'(1);

   if (ALLOW_NEG) begin : g_signed
      assign neg_o = rnd_i[LOG2W];
   end else begin : g_forward_only
      logic unused_sign;
      assign unused_sign = rnd_i[LOG2W];
      assign neg_o       = 1'b0;
   end
endmodule

// File: rtl/psel_complete.sv
module psel_complete (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic a_seen_i,
   input  logic b_seen_i,
   input  logic a_final_i,
   input  logic b_final_i,
   output logic a_done_o,
   output logic b_done_o
);
   logic a_fin_q, b_fin_q;
   logic a_now, b_now;

   // A report only counts once its slot has actually been given a tag.
   assign a_now = a_final_i && a_seen_i;
   assign b_now = b_final_i && b_seen_i;

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         a_fin_q <= 1'b0;
         b_fin_q <= 1'b0;
      end else begin
         a_fin_q <= a_fin_q | a_now;
         b_fin_q <= b_fin_q | b_now;
      end
   end

   assign a_done_o = a_fin_q | a_now;
   assign b_done_o = b_fin_q | b_now;
endmodule

// File: rtl/psel_window.sv
module psel_window
   import psel_pkg::*;
#(
   parameter int unsigned W = 16,
   localparam int unsigned LOG2W = $clog2(W),
   localparam int unsigned CW    = LOG2W + 1,
   localparam int unsigned DW    = LOG2W + 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sample_req,
   input  logic [CW-1:0] mag_i,
   input  logic          neg_i,
   input  logic          fetch_valid,
   input  logic          flush,
   input  logic          a_done_i,
   input  logic          b_done_i,
   output logic          accept_o,
   output logic          busy_o,
   output logic          a_seen_o,
   output logic          b_seen_o,
   output logic          tag_a_o,
   output logic          tag_b_o,
   output logic          pair_done_o,
   output logic          pair_valid_o,
   output logic [DW-1:0] pair_dist_o
);
   psel_state_e   state_q;
   logic [CW-1:0] cnt_q, mag_q, pos_a, pos_b;
   logic          neg_q, inval_q, a_seen_q, b_seen_q;
   logic          running, fetch_live, hit_a, hit_b, ready;

   assign running    = (state_q == PS_RUN);
   assign fetch_live = running && fetch_valid && !flush;
   assign accept_o   = (state_q == PS_IDLE) && sample_req;

   // Fetch positions of the two tags, counted from acceptance.
   assign pos_a = neg_q ? (CW'(W) - mag_q) : '0;
   assign pos_b = neg_q ? CW'(W) : mag_q;

   assign hit_a = fetch_live && !a_seen_q && (cnt_q == pos_a);
   assign hit_b = fetch_live && a_seen_q && !b_seen_q && (cnt_q == pos_b);

   assign ready = a_done_i && (inval_q || b_done_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= PS_IDLE;
         cnt_q        <= '0;
         mag_q        <= CW'(1);
         neg_q        <= 1'b0;
         inval_q      <= 1'b0;
         a_seen_q     <= 1'b0;
         b_seen_q     <= 1'b0;
         pair_done_o  <= 1'b0;
         pair_valid_o <= 1'b0;
         pair_dist_o  <= '0;
      end else begin
         pair_done_o <= 1'b0;
         unique case (state_q)
            PS_IDLE: begin
               if (sample_req) begin
                  state_q     <= PS_RUN;
                  cnt_q       <= '0;
                  mag_q       <= mag_i;
                  neg_q       <= neg_i;
                  inval_q     <= 1'b0;
                  a_seen_q    <= 1'b0;
                  b_seen_q    <= 1'b0;
                  pair_dist_o <= neg_i ? (DW'(0) - DW'(mag_i)) : DW'(mag_i);
               end
            end
            PS_RUN: begin
               if (flush) begin
                  inval_q <= 1'b1;
                  if (!a_seen_q || a_done_i) begin
                     state_q      <= PS_IDLE;
                     pair_done_o  <= 1'b1;
                     pair_valid_o <= 1'b0;
                  end else begin
                     state_q <= PS_WAIT;
                  end
               end else if (fetch_valid) begin
                  cnt_q <= cnt_q + CW'(1);
                  if (hit_a) a_seen_q <= 1'b1;
                  if (hit_b) begin
                     b_seen_q <= 1'b1;
                     state_q  <= PS_WAIT;
                  end
               end
            end
            PS_WAIT: begin
               if (ready) begin
                  state_q      <= PS_IDLE;
                  pair_done_o  <= 1'b1;
                  pair_valid_o <= !inval_q;
               end
            end
            default: state_q <= PS_IDLE;
         endcase
      end
   end

   assign busy_o   = (state_q != PS_IDLE);
   assign a_seen_o = a_seen_q;
   assign b_seen_o = b_seen_q;
   assign tag_a_o  = hit_a;
   assign tag_b_o  = hit_b;
endmodule

// File: rtl/paired_sample_sel.sv
module paired_sample_sel #(
   parameter int unsigned           W         = 16,
   parameter bit                    ALLOW_NEG = 1'b1,
   parameter int unsigned           LFSR_W    = 16,
   parameter logic [LFSR_W-1:0]     LFSR_TAPS = 16'hB400,
   parameter logic [LFSR_W-1:0]     LFSR_SEED = 16'hACE1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sample_req,
   input  logic                    fetch_valid,
   input  logic                    flush,
   input  logic                    slot_a_final,
   input  logic                    slot_b_final,
   output logic                    busy,
   output logic                    tag_a,
   output logic                    tag_b,
   output logic                    pair_done,
   output logic                    pair_valid,
   output logic [$clog2(W)+1:0]    pair_dist
);
   localparam int unsigned LOG2W = $clog2(W);
   localparam int unsigned CW    = LOG2W + 1;

   if (W < 2 || W > 64) begin : g_bad_w_range
      $error("paired_sample_sel: W must be within 2..64");
   end
   if ((1 << LOG2W) != W) begin : g_bad_w_pow2
      $error("paired_sample_sel: W must be a power of two");
   end
   if (LFSR_W <= LOG2W + 1) begin : g_bad_lfsr
      $error("paired_sample_sel: LFSR too narrow for the window");
   end

   logic [LOG2W:0] rnd;
   logic [CW-1:0]  mag;
   logic           neg, accept, a_seen, b_seen, a_done, b_done;

   psel_lfsr #(
      .LW  (LFSR_W),
      .OW  (LOG2W + 1),
      .TAPS(LFSR_TAPS),
      .SEED(LFSR_SEED)
   ) u_lfsr (
      .clk  (clk),
      .rst_n(rst_n),
      .rnd_o(rnd)
   );

   psel_offset #(
      .W        (W),
      .ALLOW_NEG(ALLOW_NEG)
   ) u_offset (
      .rnd_i(rnd),
      .mag_o(mag),
      .neg_o(neg)
   );

   psel_complete u_complete (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (accept),
      .a_seen_i (a_seen),
      .b_seen_i (b_seen),
      .a_final_i(slot_a_final),
      .b_final_i(slot_b_final),
      .a_done_o (a_done),
      .b_done_o (b_done)
   );

   psel_window #(
      .W(W)
   ) u_window (
      .clk         (clk),
      .rst_n       (rst_n),
      .sample_req  (sample_req),
      .mag_i       (mag),
      .neg_i       (neg),
      .fetch_valid (fetch_valid),
      .flush       (flush),
      .a_done_i    (a_done),
      .b_done_i    (b_done),
      .accept_o    (accept),
      .busy_o      (busy),
      .a_seen_o    (a_seen),
      .b_seen_o    (b_seen),
      .tag_a_o     (tag_a),
      .tag_b_o     (tag_b),
      .pair_done_o (pair_done),
      .pair_valid_o(pair_valid),
      .pair_dist_o (pair_dist)
   );
endmodule

// File: rtl/psel_chk.sv
module psel_chk #(
   parameter int unsigned W = 16,
   localparam int unsigned DW = $clog2(W) + 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sample_req,
   input logic          fetch_valid,
   input logic          flush,
   input logic          busy,
   input logic          tag_a,
   input logic          tag_b,
   input logic          pair_done,
   input logic          pair_valid,
   input logic [DW-1:0] pair_dist
);
   logic       a_seen_c, b_seen_c;
   logic [7:0] gap_c;
   int         mag_c;

   assign mag_c = ($signed(pair_dist) < 0) ? -int'($signed(pair_dist)) : int'($signed(pair_dist));

   always_ff @(posedge clk) begin
      if (!rst_n || (sample_req && !busy)) begin
         a_seen_c <= 1'b0;
         b_seen_c <= 1'b0;
         gap_c    <= '0;
      end else begin
         if (tag_a) begin
            a_seen_c <= 1'b1;
            gap_c    <= '0;
         end else if (a_seen_c && fetch_valid) begin
            gap_c <= gap_c + 8'd1;
         end
         if (tag_b) b_seen_c <= 1'b1;
      end
   end

   assert_no_tag_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(tag_a || tag_b));
   assert_dist_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(pair_dist));
   assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pair_done |-> !busy);
   assert_dist_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (mag_c >= 1 && mag_c <= int'(W)));
   assert_gap_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tag_b |-> (int'(gap_c) == mag_c - 1));
   assert_b_after_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tag_b |-> a_seen_c);
   assert_tags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(tag_a && tag_b));
   assert_tag_on_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_a || tag_b) |-> fetch_valid);
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pair_done |=> !pair_done);
   assert_valid_needs_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_done && pair_valid) |-> b_seen_c);
   assert_flush_blocks_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !(tag_a || tag_b));
endmodule

bind paired_sample_sel psel_chk #(.W(W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sample_req (sample_req),
   .fetch_valid(fetch_valid),
   .flush      (flush),
   .busy       (busy),
   .tag_a      (tag_a),
   .tag_b      (tag_b),
   .pair_done  (pair_done),
   .pair_valid (pair_valid),
   .pair_dist  (pair_dist)
);

// File: tb/paired_sample_sel_bench.sv
module paired_sample_sel_bench;
   localparam int W  = 16;
   localparam int DW = $clog2(W) + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sample_req = 1'b0, fetch_valid = 1'b0, flush = 1'b0;
   logic slot_a_final = 1'b0, slot_b_final = 1'b0;
   logic busy, tag_a, tag_b, pair_done, pair_valid;
   logic [DW-1:0] pair_dist;

   int checks = 0, failures = 0, cyc = 0, seen_neg = 0, seen_pos = 0;

   always #4 clk = ~clk;

   paired_sample_sel u_paired_sample_sel (
      .clk(clk), .rst_n(rst_n), .sample_req(sample_req), .fetch_valid(fetch_valid),
      .flush(flush), .slot_a_final(slot_a_final), .slot_b_final(slot_b_final),
      .busy(busy), .tag_a(tag_a), .tag_b(tag_b), .pair_done(pair_done),
      .pair_valid(pair_valid), .pair_dist(pair_dist)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   function automatic int pos_of_a(input bit neg, input int k);
      return neg ? (W - k) : 0;
   endfunction

   function automatic int pos_of_b(input bit neg, input int k);
      return neg ? W : k;
   endfunction

   // flush_at: fetch index at which flush is driven (-1 none, -3 just after tag A)
   task automatic run_pair(input int flush_at, input int fprob, input int maxdly, input bit spurious);
      int d, k, pa, pb, idx, da, db, fl_idx, iter;
      bit neg, t_a, t_b, fin_a, fin_b, inval, done_next, predicted, run;
      bit fv, fl, fa, fb;
      @(negedge clk);
      sample_req = 1'b1;
      @(negedge clk);
      sample_req = 1'b0;
      d   = $signed(pair_dist);
      neg = (d < 0);
      k   = neg ? -d : d;
      check(k >= 1 && k <= W, "R3 distance magnitude", k, 1);
      check(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
      if (neg) seen_neg++; else seen_pos++;
      pa = pos_of_a(neg, k);
      pb = pos_of_b(neg, k);
      fl_idx = (flush_at == -3) ? pa + 1 : flush_at;
      idx = 0; da = -1; db = -1;
      t_a = 0; t_b = 0; fin_a = 0; fin_b = 0; inval = 0; done_next = 0; predicted = 0;
      for (iter = 0; iter < 4000; iter++) begin
         run = !t_b && !inval && !predicted;
         fv  = ($urandom_range(99) < fprob);
         fl  = run && (fl_idx >= 0) && (idx == fl_idx);
         fa  = (t_a && !fin_a && da == 0) || (spurious && !t_a && ($urandom_range(9) == 0));
         fb  = (t_b && !fin_b && db == 0) || (spurious && !t_b && ($urandom_range(9) == 0));
         fetch_valid  = fv;
         flush        = fl;
         slot_a_final = fa;
         slot_b_final = fb;
         sample_req   = run && ($urandom_range(7) == 0);
         #1;
         check(tag_a == (run && fv && !fl && idx == pa), neg ? "R5 tag A position" : "R4 tag A position",
               int'(tag_a), int'(run && fv && !fl && idx == pa));
         check(tag_b == (run && fv && !fl && idx == pb && t_a), neg ? "R5 tag B position" : "R4 tag B position",
               int'(tag_b), int'(run && fv && !fl && idx == pb && t_a));
         check(!(tag_a && tag_b), "R6 tags exclusive", int'(tag_a && tag_b), 0);
         check(pair_done == done_next, inval ? "R8 done timing" : "R7 done timing",
               int'(pair_done), int'(done_next));
         if (done_next) begin
            check(pair_valid == !inval, inval ? "R8 pair invalid" : "R7 pair valid",
                  int'(pair_valid), int'(!inval));
            check(busy == 1'b0, "R2 busy cleared at done", int'(busy), 0);
            break;
         end
         if (da > 0) da--;
         if (db > 0) db--;
         if (fa && t_a) begin fin_a = 1; da = -1; end
         if (fb && t_b) begin fin_b = 1; db = -1; end
         if (run && fv && !fl && idx == pa) begin t_a = 1; da = $urandom_range(maxdly); end
         if (run && fv && !fl && idx == pb && t_a) begin t_b = 1; db = $urandom_range(maxdly); end
         if (fl) inval = 1;
         if (run && fv && !fl) idx++;
         done_next = !predicted && ((inval && (!t_a || fin_a)) || (t_b && fin_a && fin_b));
         if (done_next) predicted = 1;
         @(negedge clk);
      end
      check(done_next, "R7 pair completed", int'(done_next), 1);
      fetch_valid = 0; flush = 0; slot_a_final = 0; slot_b_final = 0; sample_req = 0;
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(busy == 0 && tag_a == 0 && tag_b == 0 && pair_done == 0, "R1 reset state",
            int'({busy, tag_a, tag_b, pair_done}), 0);
      // directed corners
      run_pair(-1, 100, 0, 1'b0);   // dense fetch, immediate finals
      run_pair(-1, 100, 6, 1'b1);   // spurious finals before tags (R7)
      run_pair(0, 100, 3, 1'b0);    // R8 flush before tag A
      run_pair(-3, 100, 3, 1'b0);   // R8 flush between tags
      run_pair(-3, 40, 0, 1'b0);    // R8 flush between tags, A final early
      run_pair(-1, 20, 10, 1'b0);   // sparse fetch
      for (int n = 0; n < 80; n++) begin
         int sel;
         sel = $urandom_range(9);
         run_pair((sel == 0) ? 0 : (sel == 1) ? -3 : (sel == 2) ? int'($urandom_range(W)) : -1,
                  $urandom_range(100, 20), $urandom_range(12), sel[0]);
      end
      check(seen_neg > 0, "R3 negative distances seen", seen_neg, 1);
      check(seen_pos > 0, "R3 positive distances seen", seen_pos, 1);
      repeat (2) @(negedge clk);
      #1;
      check(busy == 0 && tag_a == 0 && tag_b == 0, "R1 quiet when idle",
            int'({busy, tag_a, tag_b}), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule